// File: doc/BRIEF.md
# Receive Frame Address Reject Controller

This block sits between the byte stream of an Ethernet receiver and the writer that stores frames into a ring of fixed-size receive buffers. Each accepted byte becomes a buffer write that names a buffer index and a byte offset. A frame fills buffers in order, starting at the ring's current start buffer. When the frame's last byte is written, a status descriptor is issued with the frame's start buffer and its length. The next frame then begins in the buffer after the last one used.

An external address-match engine looks at the frame while the frame is being received. It accepts the frame by staying silent. It vetoes the frame by raising `reject_i`, and the veto counts only while the frame is still in progress. On a veto, writes stop in that same byte cycle. The rest of the frame is consumed without being stored, and no descriptor is issued. A one-cycle reclaim pulse returns the start buffer index, so the next frame reuses the same buffers.

A collision flagged by the receiver during a frame does three things. It sends a one-cycle abort to the match engine, which cancels its pending lookup. It drops the frame in the same way as a veto. It also triggers the reclaim pulse. A new start of frame that arrives while the block is still discarding is held off: it is discarded too, up to the next end-of-frame marker.

Top module: `rx_reject_ctrl`

## Requirements
- R1: After reset, `wr_valid_o`, `desc_valid_o`, `reclaim_o` and `lookup_abort_o` are 0, and `state_o` is 0. The state encoding is 0 idle, 1 receiving, 2 dropping, 3 done.
- R2: Each byte of an accepted frame appears on `wr_valid_o`/`wr_data_o` one cycle after it is presented.
  - The first byte goes to offset 0 of the start buffer.
  - The offset increases by one per byte, and after `BUF_BYTES` bytes writing moves to the next buffer index, modulo `NUM_BUF`.
  - One cycle after the byte flagged end-of-frame, `desc_valid_o` pulses with `desc_buf_o` equal to the start buffer and `desc_len_o` equal to the byte count, and `state_o` is 3.
  - A start of frame presented while `state_o` is 3 begins a new frame at once.
- R3: When `reject_i` is high during a frame, the byte presented in that cycle and every later byte of the frame produce no write. No descriptor is issued for the frame.
- R4: One cycle after an honoured reject, `reclaim_o` pulses for one cycle with `reclaim_idx_o` equal to the frame's start buffer. The next frame starts at that same buffer.
- R5: `reject_i` has no effect when no frame is in progress, that is while `state_o` is 0 or 3 and no start of frame is presented. In that case no reclaim is issued, and the next frame starts after the buffers of the last accepted frame.
- R6: A collision (`rx_col_i` high) during a frame pulses `lookup_abort_o` one cycle later. The frame is then handled as rejected: there are no further writes, `reclaim_o` pulses with the start buffer, and no descriptor is issued.
- R7: While `state_o` is 2, bytes produce no writes. The byte flagged end-of-frame returns `state_o` to 0.
- R8: A start of frame presented while `state_o` is 2 does not begin a frame. Its bytes are discarded up to the next end-of-frame marker.
- R9: A reject presented together with the start-of-frame byte drops the frame from its first byte. If that byte is also flagged end-of-frame, `state_o` returns directly to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | DATA_W | Receive byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| reject_i | input | 1 | Veto from the address-match engine |
| rx_col_i | input | 1 | Collision on the incoming frame |
| wr_valid_o | output | 1 | Buffer write strobe |
| wr_buf_o | output | BUF_W | Buffer index of the write |
| wr_off_o | output | OFF_W | Byte offset within the buffer |
| wr_data_o | output | DATA_W | Write data |
| desc_valid_o | output | 1 | Status descriptor strobe for an accepted frame |
| desc_buf_o | output | BUF_W | Start buffer of the accepted frame |
| desc_len_o | output | LEN_W | Length of the accepted frame in bytes |
| reclaim_o | output | 1 | One-cycle buffer reclaim pulse |
| reclaim_idx_o | output | BUF_W | Start buffer to reuse |
| lookup_abort_o | output | 1 | One-cycle abort to the address-match engine |
| state_o | output | 2 | Frame state |

## Verification
Every result of this block is registered once. The write, descriptor, reclaim, abort and state outputs therefore reflect the inputs of one rising edge and are due in the cycle directly after it. The bench changes inputs on the falling edge and reads outputs shortly after the following rising edge, so each check sees exactly the reaction to the byte or veto just presented. Ignored-reject cases are judged through the reclaim output and through the buffer index that the next frame's first write uses.

// File: rtl/rx_rej_pkg.sv
package rx_rej_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_DONE = 2'd3
  } frame_st_e;
endpackage

// File: rtl/rx_rej_fsm.sv
module rx_rej_fsm
  import rx_rej_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rx_valid_i,
  input  logic      rx_sof_i,
  input  logic      rx_eof_i,
  input  logic      reject_i,
  input  logic      rx_col_i,
  output frame_st_e st_o,
  output logic      accept_sof_o,
  output logic      write_o,
  output logic      eof_ok_o,
  output logic      kill_o,
  output logic      abort_o
);
  frame_st_e st_q, st_d;
  logic in_frame;

  assign accept_sof_o = rx_valid_i && rx_sof_i && (st_q == ST_IDLE || st_q == ST_DONE);
  // veto window: open from the start byte up to and including the end byte
  assign in_frame     = accept_sof_o || (st_q == ST_RECV);
  assign kill_o       = in_frame && (reject_i || rx_col_i);
  assign abort_o      = in_frame && rx_col_i;
  assign write_o      = rx_valid_i && in_frame && !kill_o;
  assign eof_ok_o     = write_o && rx_eof_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept_sof_o) begin
          if (kill_o) st_d = rx_eof_i ? ST_IDLE : ST_DROP;
          else        st_d = rx_eof_i ? ST_DONE : ST_RECV;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_RECV: begin
        if (kill_o)        st_d = (rx_valid_i && rx_eof_i) ? ST_IDLE : ST_DROP;
        else if (eof_ok_o) st_d = ST_DONE;
      end
      ST_DROP: begin
        // a new start of frame here is held off: drop through to the next end
        if (rx_valid_i && rx_eof_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/rx_rej_bufptr.sv
module rx_rej_bufptr #(
  parameter int NUM_BUF   = 8,
  parameter int BUF_BYTES = 64,
  localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int OFF_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LEN_W    = $clog2(NUM_BUF * BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_sof_i,
  input  logic             write_i,
  input  logic             eof_ok_i,
  output logic [BUF_W-1:0] addr_buf_o,
  output logic [OFF_W-1:0] addr_off_o,
  output logic [BUF_W-1:0] start_buf_o,
  output logic [LEN_W-1:0] len_next_o
);
  logic [BUF_W-1:0] head_q, cur_q, buf_inc;
  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;
  logic             off_last;

  // head only moves on a completed frame, so it is the current frame's start
  assign addr_buf_o  = accept_sof_i ? head_q : cur_q;
  assign addr_off_o  = accept_sof_i ? '0 : off_q;
  assign len_next_o  = (accept_sof_i ? '0 : len_q) + 1'b1;
  assign start_buf_o = head_q;
  assign off_last    = (addr_off_o == OFF_W'(BUF_BYTES - 1));
  assign buf_inc     = (addr_buf_o == BUF_W'(NUM_BUF - 1)) ? '0 : addr_buf_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cur_q  <= '0;
      off_q  <= '0;
      len_q  <= '0;
    end else begin
      if (write_i) begin
        off_q <= off_last ? '0 : addr_off_o + 1'b1;
        cur_q <= off_last ? buf_inc : addr_buf_o;
        len_q <= len_next_o;
      end
      if (eof_ok_i) head_q <= buf_inc;
    end
  end
endmodule

// File: rtl/rx_rej_out.sv
module rx_rej_out #(
  parameter int DATA_W = 8,
  parameter int BUF_W  = 3,
  parameter int OFF_W  = 6,
  parameter int LEN_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              write_i,
  input  logic              eof_ok_i,
  input  logic              kill_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BUF_W-1:0]  addr_buf_i,
  input  logic [OFF_W-1:0]  addr_off_i,
  input  logic [BUF_W-1:0]  start_buf_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              wr_valid_o,
  output logic [BUF_W-1:0]  wr_buf_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              desc_valid_o,
  output logic [BUF_W-1:0]  desc_buf_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic              reclaim_o,
  output logic [BUF_W-1:0]  reclaim_idx_o,
  output logic              lookup_abort_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o     <= 1'b0;
      wr_buf_o       <= '0;
      wr_off_o       <= '0;
      wr_data_o      <= '0;
      desc_valid_o   <= 1'b0;
      desc_buf_o     <= '0;
      desc_len_o     <= '0;
      reclaim_o      <= 1'b0;
      reclaim_idx_o  <= '0;
      lookup_abort_o <= 1'b0;
    end else begin
      wr_valid_o     <= write_i;
      desc_valid_o   <= eof_ok_i;
      reclaim_o      <= kill_i;
      lookup_abort_o <= abort_i;
      if (write_i) begin
        wr_buf_o  <= addr_buf_i;
        wr_off_o  <= addr_off_i;
        wr_data_o <= data_i;
      end
      if (eof_ok_i) begin
        desc_buf_o <= start_buf_i;
        desc_len_o <= len_i;
      end
      if (kill_i) reclaim_idx_o <= start_buf_i;
    end
  end
endmodule

// File: rtl/rx_reject_ctrl.sv
module rx_reject_ctrl
  import rx_rej_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BUF   = 8,
  parameter int BUF_BYTES = 64,
  localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int OFF_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LEN_W    = $clog2(NUM_BUF * BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              reject_i,
  input  logic              rx_col_i,
  output logic              wr_valid_o,
  output logic [BUF_W-1:0]  wr_buf_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              desc_valid_o,
  output logic [BUF_W-1:0]  desc_buf_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic              reclaim_o,
  output logic [BUF_W-1:0]  reclaim_idx_o,
  output logic              lookup_abort_o,
  output logic [1:0]        state_o
);
  frame_st_e        st;
  logic             accept_sof, write, eof_ok, kill, abort;
  logic [BUF_W-1:0] addr_buf, start_buf;
  logic [OFF_W-1:0] addr_off;
  logic [LEN_W-1:0] len_next;

  rx_rej_fsm u_fsm (
    .clk_i, .rst_ni, .rx_valid_i, .rx_sof_i, .rx_eof_i, .reject_i, .rx_col_i,
    .st_o(st), .accept_sof_o(accept_sof), .write_o(write),
    .eof_ok_o(eof_ok), .kill_o(kill), .abort_o(abort)
  );

  rx_rej_bufptr #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_ptr (
    .clk_i, .rst_ni, .accept_sof_i(accept_sof), .write_i(write), .eof_ok_i(eof_ok),
    .addr_buf_o(addr_buf), .addr_off_o(addr_off),
    .start_buf_o(start_buf), .len_next_o(len_next)
  );

  rx_rej_out #(.DATA_W(DATA_W), .BUF_W(BUF_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_out (
    .clk_i, .rst_ni, .write_i(write), .eof_ok_i(eof_ok), .kill_i(kill), .abort_i(abort),
    .data_i(rx_data_i), .addr_buf_i(addr_buf), .addr_off_i(addr_off),
    .start_buf_i(start_buf), .len_i(len_next),
    .wr_valid_o, .wr_buf_o, .wr_off_o, .wr_data_o,
    .desc_valid_o, .desc_buf_o, .desc_len_o,
    .reclaim_o, .reclaim_idx_o, .lookup_abort_o
  );

  assign state_o = st;

  AST_DESC_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (st == ST_DONE)); // R2
  AST_REJ_NO_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reclaim_o |-> !desc_valid_o); // R3
  AST_IDLE_REJ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_IDLE || st == ST_DONE) && !(rx_valid_i && rx_sof_i)) |=> !reclaim_o); // R5
  AST_ABORT_RECLAIMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_abort_o |-> reclaim_o); // R6
  AST_DROP_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DROP) |=> !wr_valid_o); // R7
endmodule

// File: tb/sim_rx_reject_ctrl.sv
`timescale 1ns/1ps
module sim_rx_reject_ctrl;
  localparam int NB = 4;
  localparam int BB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, reject = 0, rx_col = 0;
  logic [7:0] rx_data = '0;
  logic       wr_valid, desc_valid, reclaim, lookup_abort;
  logic [1:0] wr_buf, desc_buf, reclaim_idx, state;
  logic [1:0] wr_off;
  logic [4:0] desc_len;

  int total = 0, bad = 0, h = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_reject_ctrl #(.DATA_W(8), .NUM_BUF(NB), .BUF_BYTES(BB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .reject_i(reject), .rx_col_i(rx_col),
    .wr_valid_o(wr_valid), .wr_buf_o(wr_buf), .wr_off_o(wr_off), .wr_data_o(rx_data_q),
    .desc_valid_o(desc_valid), .desc_buf_o(desc_buf), .desc_len_o(desc_len),
    .reclaim_o(reclaim), .reclaim_idx_o(reclaim_idx),
    .lookup_abort_o(lookup_abort), .state_o(state)
  );
  logic [7:0] rx_data_q;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, s, e, input logic [7:0] d, input logic rj, cl);
    @(negedge clk);
    rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d; reject = rj; rx_col = cl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 8'h00, 0, 0);
  endtask

  // accepted frame of n bytes, every write and the descriptor checked
  task automatic send_ok(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(i * 7 + n + h);
      cyc(1, i == 0, i == n - 1, d, 0, 0);
      chk(req, "wr_valid", wr_valid, 1);
      chk(req, "wr_buf", wr_buf, (h + i / BB) % NB);
      chk(req, "wr_off", wr_off, i % BB);
      chk(req, "wr_data", rx_data_q, d);
      if (i == n - 1) begin
        chk(req, "desc_valid", desc_valid, 1);
        chk(req, "desc_buf", desc_buf, h);
        chk(req, "desc_len", desc_len, n);
        chk(req, "state done", state, 3);
      end else begin
        chk(req, "state recv", state, 1);
      end
    end
    h = (h + (n - 1) / BB + 1) % NB;
  endtask

  task automatic t_reset();
    chk("R1", "wr_valid", wr_valid, 0);
    chk("R1", "desc_valid", desc_valid, 0);
    chk("R1", "reclaim", reclaim, 0);
    chk("R1", "lookup_abort", lookup_abort, 0);
    chk("R1", "state", state, 0);
  endtask

  task automatic t_accept();
    send_ok(6, "R2");
    idle();
    chk("R2", "desc pulse ends", desc_valid, 0);
    chk("R2", "state idle", state, 0);
    send_ok(1, "R2");
    send_ok(5, "R2");   // starts straight from done state
    send_ok(2, "R2");
    idle();
  endtask

  task automatic t_reject();
    int s = h;
    cyc(1, 1, 0, 8'h11, 0, 0);
    cyc(1, 0, 0, 8'h12, 0, 0);
    cyc(1, 0, 0, 8'h13, 1, 0);
    chk("R3", "no write on reject byte", wr_valid, 0);
    chk("R4", "reclaim", reclaim, 1);
    chk("R4", "reclaim_idx", reclaim_idx, s);
    chk("R7", "state drop", state, 2);
    cyc(1, 0, 0, 8'h14, 0, 0);
    chk("R4", "reclaim one cycle", reclaim, 0);
    chk("R7", "no write while dropping", wr_valid, 0);
    cyc(1, 0, 1, 8'h15, 0, 0);
    chk("R3", "no write on eof", wr_valid, 0);
    chk("R3", "no descriptor", desc_valid, 0);
    chk("R7", "state idle after eof", state, 0);
    idle();
    chk("R3", "no late descriptor", desc_valid, 0);
    send_ok(3, "R4");  // reuses start buffer s == h
    idle();
  endtask

  task automatic t_late_reject();
    int s;
    send_ok(2, "R5");
    s = h;
    cyc(0, 0, 0, 8'h00, 1, 0);
    chk("R5", "reject in done ignored", reclaim, 0);
    chk("R5", "state idle", state, 0);
    cyc(0, 0, 0, 8'h00, 1, 0);
    chk("R5", "reject in idle ignored", reclaim, 0);
    idle();
    cyc(1, 1, 0, 8'h21, 0, 0);
    chk("R5", "next frame start buffer", wr_buf, s);
    cyc(1, 0, 1, 8'h22, 0, 0);
    chk("R5", "frame completes", desc_valid, 1);
    h = (h + 1) % NB;
    idle();
  endtask

  task automatic t_collision();
    int s = h;
    cyc(1, 1, 0, 8'h31, 0, 0);
    cyc(1, 0, 0, 8'h32, 0, 1);
    chk("R6", "lookup_abort", lookup_abort, 1);
    chk("R6", "reclaim", reclaim, 1);
    chk("R6", "reclaim_idx", reclaim_idx, s);
    chk("R6", "no write", wr_valid, 0);
    chk("R6", "state drop", state, 2);
    cyc(1, 0, 0, 8'h33, 0, 0);
    chk("R6", "abort one cycle", lookup_abort, 0);
    cyc(1, 0, 1, 8'h34, 0, 0);
    chk("R6", "no descriptor", desc_valid, 0);
    chk("R7", "idle after eof", state, 0);
    idle();
  endtask

  task automatic t_holdoff();
    int s = h;
    cyc(1, 1, 0, 8'h41, 0, 0);
    cyc(1, 0, 0, 8'h42, 1, 0);
    chk("R8", "dropping", state, 2);
    cyc(1, 1, 0, 8'h43, 0, 0);   // new start while dropping
    chk("R8", "held off no write", wr_valid, 0);
    chk("R8", "state stays drop", state, 2);
    chk("R8", "no second reclaim", reclaim, 0);
    cyc(1, 0, 0, 8'h44, 0, 0);
    chk("R8", "still no write", wr_valid, 0);
    cyc(1, 0, 1, 8'h45, 0, 0);
    chk("R8", "idle after eof", state, 0);
    chk("R8", "no descriptor", desc_valid, 0);
    idle();
    cyc(1, 1, 1, 8'h46, 0, 0);
    chk("R8", "next start buffer", wr_buf, s);
    chk("R8", "desc len", desc_len, 1);
    h = (h + 1) % NB;
    idle();
  endtask

  task automatic t_sof_reject();
    int s = h;
    cyc(1, 1, 0, 8'h51, 1, 0);
    chk("R9", "no first write", wr_valid, 0);
    chk("R9", "reclaim", reclaim, 1);
    chk("R9", "reclaim_idx", reclaim_idx, s);
    chk("R9", "state drop", state, 2);
    cyc(1, 0, 1, 8'h52, 0, 0);
    chk("R9", "idle", state, 0);
    cyc(1, 1, 1, 8'h53, 1, 0);
    chk("R9", "single byte killed", wr_valid, 0);
    chk("R9", "reclaim single", reclaim, 1);
    chk("R9", "direct to idle", state, 0);
    chk("R9", "no descriptor", desc_valid, 0);
    idle();
    send_ok(4, "R9");
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_accept();
    t_reject();
    t_late_reject();
    t_collision();
    t_holdoff();
    t_sof_reject();
    t_accept();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule